// File: doc/BRIEF.md
# Dual-Priority Conversion Queue Scheduler

This block shares one conversion engine between two command queues. Queue 1 has the higher priority and queue 2 the lower. Each queue has its own trigger input. Once triggered, a queue walks its list of command words one conversion at a time. For each conversion the block issues a start strobe together with the command address, and it advances when the converter returns a done strobe. Each command word carries two markers, read back through two inputs for the address currently on `cmdAddr`. A pause marker suspends the queue after that command. An end marker finishes the queue.

A queue 1 trigger always wins the engine. If queue 2 is converting, its conversion is aborted in the same cycle that queue 1's first command is started. Queue 2 then waits and later restarts from its first command. A queue 2 trigger that arrives while queue 1 runs is held as pending. A second such trigger is reported as an overrun rather than queued. Pause, completion and overrun flags are sticky per queue and are cleared by a write-one-to-clear input. A 4-bit status code shows the state of both queues.

Top module: `convQueueSched`

## Requirements
- R1: After reset, `convStart`, `convAbort`, all flags and `queueStatus` are zero.
- R2: A queue 1 trigger while queue 1 is idle produces `convStart` in the next cycle, with `cmdQueue`=0 and `cmdAddr`=Q1_BASE.
- R3: On `convDone`, the active queue acts on the markers of the current command. With neither marker it starts the next address in the following cycle. With the end marker, or when the command sits in the queue's last slot (index DEPTH-1), it sets its completion flag and goes idle without a further start.
- R4: A done on a command with the pause marker and no end marker sets that queue's pause flag and moves the queue to paused with no further start. A new trigger to the paused queue resumes it at the command after the paused one.
- R5: A queue 1 trigger while queue 2 is converting asserts `convAbort` and a queue 1 `convStart` in the same cycle. Queue 2 then waits with status 11 and, when queue 1 goes idle or pauses, restarts at Q2_BASE.
- R6: A single queue 2 trigger while queue 1 is active makes queue 2 pending, with status 11, and does not disturb queue 1. Queue 2 starts when queue 1 goes idle or pauses: at Q2_BASE if it was idle, or at the next command if it was paused.
- R7: A queue 2 trigger while queue 2 is already pending, waiting or active sets `torFlag[1]` and changes nothing else.
- R8: A queue 1 trigger while queue 1 is active sets `torFlag[0]` and causes no start.
- R9: Flags are sticky until written one on `flagClr`. The bit map is 0 pause1, 1 pause2, 2 comp1, 3 comp2, 4 tor1, 5 tor2. A flag set in the same cycle as its clear stays set.
- R10: `queueStatus` = {queue 1 code, queue 2 code}. Each code is 00 idle, 10 active, 01 paused or 11 waiting (pending or suspended). Queue 1 never shows 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig1 | input | 1 | Queue 1 trigger, one-cycle pulse |
| trig2 | input | 1 | Queue 2 trigger, one-cycle pulse |
| convDone | input | 1 | Conversion finished pulse from the engine |
| cmdPause | input | 1 | Pause marker of the command at `cmdAddr` |
| cmdLast | input | 1 | End marker of the command at `cmdAddr` |
| flagClr | input | 6 | Write-one-to-clear for the flags (map in R9) |
| convStart | output | 1 | Start a conversion of the command at `cmdAddr` |
| convAbort | output | 1 | Abort the conversion in flight |
| cmdQueue | output | 1 | Queue owning the started command (0 = queue 1) |
| cmdAddr | output | ADDR_W | Command word address |
| pauseFlag | output | 2 | Sticky pause flags, bit 0 queue 1 |
| compFlag | output | 2 | Sticky completion flags, bit 0 queue 1 |
| torFlag | output | 2 | Sticky trigger-overrun flags, bit 0 queue 1 |
| queueStatus | output | 4 | Queue status code (R10) |

## Verification
The hardest case to reach is a queue 2 that is paused, then made pending by a trigger during a queue 1 run, and then has to resume after its pause point rather than at its first command. The bench gets there in stages. A queue 2 run stops on a pause-marked command. Queue 1 is then triggered, and queue 2 is triggered one cycle later, inside queue 1's first conversion. The scoreboard expects a queue 2 start at the address after the pause. A second hard case is the abort, which needs queue 1 triggered while queue 2's conversion is still counting down in the bench's fixed-latency converter model. The bench places that trigger two cycles after queue 2's start.

// File: rtl/convQueueSchedPkg.sv
package convQueueSchedPkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_PAUSE = 2'b01,
    QS_ACT   = 2'b10,
    QS_WAIT  = 2'b11
  } qState_t;

  // flag bit positions
  localparam int F_PAUSE1 = 0;
  localparam int F_PAUSE2 = 1;
  localparam int F_COMP1  = 2;
  localparam int F_COMP2  = 3;
  localparam int F_TOR1   = 4;
  localparam int F_TOR2   = 5;
  localparam int N_FLAGS  = 6;

  typedef struct packed {
    logic               ld1;
    logic               inc1;
    logic               ld2;
    logic               inc2;
    logic               start1;
    logic               start2;
    logic               abort;
    logic [N_FLAGS-1:0] setFlag;
  } strobes_t;

endpackage

// File: rtl/convQueueCtrl.sv
module convQueueCtrl
  import convQueueSchedPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trig1,
  input  logic     trig2,
  input  logic     convDone,
  input  logic     cmdPause,
  input  logic     cmdLast,
  input  logic     atEnd1,
  input  logic     atEnd2,
  output strobes_t stb,
  output qState_t  q1St,
  output qState_t  q2St
);

  qState_t n1, n2;
  logic    q1Go;

  always_comb begin
    stb  = '0;
    n1   = q1St;
    n2   = q2St;
    q1Go = trig1 && (q1St != QS_ACT);

    // queue 1 retrigger while active: overrun only
    if (trig1 && q1St == QS_ACT) stb.setFlag[F_TOR1] = 1'b1;

    // completion of a queue 1 command
    if (q1St == QS_ACT && convDone) begin
      if (cmdLast || atEnd1) begin
        stb.setFlag[F_COMP1] = 1'b1;
        n1 = QS_IDLE;
      end else if (cmdPause) begin
        stb.setFlag[F_PAUSE1] = 1'b1;
        stb.inc1 = 1'b1;
        n1 = QS_PAUSE;
      end else begin
        stb.inc1   = 1'b1;
        stb.start1 = 1'b1;
      end
    end

    // completion of a queue 2 command (a queue 1 trigger overrides it)
    if (q2St == QS_ACT && convDone && !q1Go) begin
      if (cmdLast || atEnd2) begin
        stb.setFlag[F_COMP2] = 1'b1;
        n2 = QS_IDLE;
      end else if (cmdPause) begin
        stb.setFlag[F_PAUSE2] = 1'b1;
        stb.inc2 = 1'b1;
        n2 = QS_PAUSE;
      end else begin
        stb.inc2   = 1'b1;
        stb.start2 = 1'b1;
      end
    end

    // queue 1 takes the engine, aborting queue 2 if it converts
    if (q1Go) begin
      n1 = QS_ACT;
      stb.start1 = 1'b1;
      if (q1St == QS_IDLE) stb.ld1 = 1'b1;
      if (q2St == QS_ACT) begin
        stb.abort = 1'b1;
        stb.ld2   = 1'b1;
        n2        = QS_WAIT;
      end
    end

    // queue 2 trigger
    if (trig2) begin
      if (n1 == QS_ACT) begin
        unique case (n2)
          QS_IDLE:  begin n2 = QS_WAIT; stb.ld2 = 1'b1; end
          QS_PAUSE: n2 = QS_WAIT;
          default:  stb.setFlag[F_TOR2] = 1'b1;
        endcase
      end else begin
        unique case (n2)
          QS_IDLE:  begin n2 = QS_ACT; stb.ld2 = 1'b1; stb.start2 = 1'b1; end
          QS_PAUSE: begin n2 = QS_ACT; stb.start2 = 1'b1; end
          default:  stb.setFlag[F_TOR2] = 1'b1;
        endcase
      end
    end

    // waiting queue 2 gets the engine once queue 1 lets go
    if (n1 != QS_ACT && n2 == QS_WAIT) begin
      n2 = QS_ACT;
      stb.start2 = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q1St <= QS_IDLE;
      q2St <= QS_IDLE;
    end else begin
      q1St <= n1;
      q2St <= n2;
    end
  end

  // R5: the engine is never owned by both queues
  p_one_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(q1St == QS_ACT && q2St == QS_ACT));

  // R10: queue 1 has no waiting code
  p_q1_no_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    q1St != QS_WAIT);

  // R5: a waiting queue 2 starts as soon as queue 1 is no longer active
  p_wait_promote_r5: assert property (@(posedge clk) disable iff (!rstN)
    (q2St == QS_WAIT) |-> (q1St == QS_ACT));

endmodule

// File: rtl/convQueueDatapath.sv
module convQueueDatapath
  import convQueueSchedPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DEPTH   = 16,
  parameter int Q1_BASE = 0,
  parameter int Q2_BASE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [N_FLAGS-1:0] flagClr,
  output logic               atEnd1,
  output logic               atEnd2,
  output logic               convStart,
  output logic               convAbort,
  output logic               cmdQueue,
  output logic [ADDR_W-1:0]  cmdAddr,
  output logic [N_FLAGS-1:0] flags
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr1, ptr2, nPtr1, nPtr2;

  always_comb begin
    nPtr1 = stb.ld1 ? '0 : (stb.inc1 ? ptr1 + 1'b1 : ptr1);
    nPtr2 = stb.ld2 ? '0 : (stb.inc2 ? ptr2 + 1'b1 : ptr2);
  end

  assign atEnd1 = (ptr1 == LAST_IDX);
  assign atEnd2 = (ptr2 == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr1      <= '0;
      ptr2      <= '0;
      convStart <= 1'b0;
      convAbort <= 1'b0;
      cmdQueue  <= 1'b0;
      cmdAddr   <= '0;
      flags     <= '0;
    end else begin
      ptr1      <= nPtr1;
      ptr2      <= nPtr2;
      convStart <= stb.start1 | stb.start2;
      convAbort <= stb.abort;
      if (stb.start1) begin
        cmdQueue <= 1'b0;
        cmdAddr  <= ADDR_W'(Q1_BASE) + ADDR_W'(nPtr1);
      end else if (stb.start2) begin
        cmdQueue <= 1'b1;
        cmdAddr  <= ADDR_W'(Q2_BASE) + ADDR_W'(nPtr2);
      end
      flags <= (flags & ~flagClr) | stb.setFlag;
    end
  end

  // R5: an abort always comes with a queue 1 start
  p_abort_paired_r5: assert property (@(posedge clk) disable iff (!rstN)
    convAbort |-> (convStart && !cmdQueue));

  // R9: a flag stays set unless cleared
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flags[F_TOR2] && !flagClr[F_TOR2]) |=> flags[F_TOR2]);

endmodule

// File: rtl/convQueueSched.sv
module convQueueSched
  import convQueueSchedPkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DEPTH   = 16,
  parameter int Q1_BASE = 0,
  parameter int Q2_BASE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trig1,
  input  logic              trig2,
  input  logic              convDone,
  input  logic              cmdPause,
  input  logic              cmdLast,
  input  logic [5:0]        flagClr,
  output logic              convStart,
  output logic              convAbort,
  output logic              cmdQueue,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [1:0]        pauseFlag,
  output logic [1:0]        compFlag,
  output logic [1:0]        torFlag,
  output logic [3:0]        queueStatus
);

  strobes_t           stb;
  qState_t            q1St, q2St;
  logic               atEnd1, atEnd2;
  logic [N_FLAGS-1:0] flags;

  convQueueCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .trig1    (trig1),
    .trig2    (trig2),
    .convDone (convDone),
    .cmdPause (cmdPause),
    .cmdLast  (cmdLast),
    .atEnd1   (atEnd1),
    .atEnd2   (atEnd2),
    .stb      (stb),
    .q1St     (q1St),
    .q2St     (q2St)
  );

  convQueueDatapath #(
    .ADDR_W  (ADDR_W),
    .DEPTH   (DEPTH),
    .Q1_BASE (Q1_BASE),
    .Q2_BASE (Q2_BASE)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .flagClr   (flagClr),
    .atEnd1    (atEnd1),
    .atEnd2    (atEnd2),
    .convStart (convStart),
    .convAbort (convAbort),
    .cmdQueue  (cmdQueue),
    .cmdAddr   (cmdAddr),
    .flags     (flags)
  );

  assign pauseFlag   = {flags[F_PAUSE2], flags[F_PAUSE1]};
  assign compFlag    = {flags[F_COMP2],  flags[F_COMP1]};
  assign torFlag     = {flags[F_TOR2],   flags[F_TOR1]};
  assign queueStatus = {q1St, q2St};

  // R2: a queue 1 trigger to a non-active queue 1 starts queue 1 next cycle
  p_q1_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (trig1 && queueStatus[3:2] != 2'b10) |=> (convStart && !cmdQueue));

  // R8: a queue 1 retrigger while active records an overrun
  p_q1_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (trig1 && queueStatus[3:2] == 2'b10) |=> torFlag[0]);

endmodule

// File: tb/tb_convQueueSched.sv
module tb_convQueueSched;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig1 = 1'b0, trig2 = 1'b0;
  logic convDone;
  logic cmdPause, cmdLast;
  logic [5:0] flagClr = '0;
  logic convStart, convAbort, cmdQueue;
  logic [ADDR_W-1:0] cmdAddr;
  logic [1:0] pauseFlag, compFlag, torFlag;
  logic [3:0] queueStatus;

  logic [1:0] tab [0:63];   // {pause, last}
  int cnt;
  int checks = 0, failures = 0;
  logic [7:0] expQ[$];      // {abort, queue, addr}

  always #(CLK_PERIOD/2) clk = ~clk;

  convQueueSched dut (
    .clk(clk), .rstN(rstN), .trig1(trig1), .trig2(trig2), .convDone(convDone),
    .cmdPause(cmdPause), .cmdLast(cmdLast), .flagClr(flagClr),
    .convStart(convStart), .convAbort(convAbort), .cmdQueue(cmdQueue),
    .cmdAddr(cmdAddr), .pauseFlag(pauseFlag), .compFlag(compFlag),
    .torFlag(torFlag), .queueStatus(queueStatus)
  );

  assign cmdPause = tab[cmdAddr][1];
  assign cmdLast  = tab[cmdAddr][0];

  // fixed-latency converter model; a new start restarts the count
  always @(posedge clk) begin
    if (!rstN) begin
      cnt <= 0;
      convDone <= 1'b0;
    end else begin
      convDone <= 1'b0;
      if (convStart) cnt <= LAT;
      else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) convDone <= 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit ab, input bit q, input int a);
    expQ.push_back({ab, q, 6'(a)});
  endtask

  // monitor: compare each start against the scoreboard
  always @(negedge clk) begin
    if (rstN && convStart) begin
      if (expQ.size() == 0) check(1'b0, "R3 unexpected start", {convAbort, cmdQueue, cmdAddr}, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check({convAbort, cmdQueue, cmdAddr} == e, "R3/R5 start item",
              {convAbort, cmdQueue, cmdAddr}, e);
      end
    end
    if (rstN && convAbort && !convStart) check(1'b0, "R5 lone abort", 1, 0);
  end

  task automatic pulse1(); @(negedge clk); trig1 = 1'b1; @(negedge clk); trig1 = 1'b0; endtask
  task automatic pulse2(); @(negedge clk); trig2 = 1'b1; @(negedge clk); trig2 = 1'b0; endtask
  task automatic clr(input logic [5:0] m); @(negedge clk); flagClr = m; @(negedge clk); flagClr = '0; endtask
  task automatic waitStatus(input logic [3:0] s);
    do @(negedge clk); while (queueStatus != s);
  endtask

  task automatic setTable();
    for (int i = 0; i < 64; i++) tab[i] = 2'b00;
    tab[2]  = 2'b01;   // q1: 0,1,2 end
    tab[17] = 2'b10;   // q2: 16,17 pause
    tab[19] = 2'b01;   //     18,19 end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    setTable();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(convStart == 0 && convAbort == 0, "R1 strobes", {convStart, convAbort}, 0);
    check({pauseFlag, compFlag, torFlag} == 0 && queueStatus == 0, "R1 flags/status",
          {pauseFlag, compFlag, torFlag, queueStatus}, 0);
    rstN = 1'b1;

    // R2/R3: plain queue 1 run
    push(0, 0, 0); push(0, 0, 1); push(0, 0, 2);
    pulse1();
    check(queueStatus == 4'b1000, "R2 R10 status q1 active", queueStatus, 4'b1000);
    waitStatus(4'b0000);
    check(compFlag == 2'b01, "R3 comp1 set", compFlag, 2'b01);
    clr(6'b000100);
    check(compFlag == 2'b00, "R9 comp1 cleared", compFlag, 0);

    // R4: queue 2 pauses, then resumes after the paused command
    push(0, 1, 16); push(0, 1, 17);
    pulse2();
    waitStatus(4'b0001);
    check(pauseFlag == 2'b10, "R4 pause2 flag", pauseFlag, 2'b10);
    check(expQ.size() == 0, "R4 no start while paused", expQ.size(), 0);
    push(0, 1, 18); push(0, 1, 19);
    pulse2();
    waitStatus(4'b0000);
    check(compFlag == 2'b10, "R3 comp2 set", compFlag, 2'b10);
    clr(6'b111111);

    // R5: queue 1 aborts a queue 2 conversion in flight
    push(0, 1, 16);
    push(1, 0, 0); push(0, 0, 1); push(0, 0, 2);
    push(0, 1, 16); push(0, 1, 17);
    pulse2();
    @(negedge clk);
    pulse1();
    check(queueStatus == 4'b1011, "R5 abort status", queueStatus, 4'b1011);
    waitStatus(4'b0001);
    check(expQ.size() == 0, "R5 q2 restarted at base", expQ.size(), 0);
    push(0, 1, 18); push(0, 1, 19);
    pulse2();
    waitStatus(4'b0000);
    clr(6'b111111);

    // R6/R7: queue 2 pending during queue 1, then overrun
    push(0, 0, 0); push(0, 0, 1); push(0, 0, 2);
    push(0, 1, 16); push(0, 1, 17);
    pulse1();
    pulse2();
    check(queueStatus == 4'b1011 && torFlag == 0, "R6 pending", {torFlag, queueStatus}, 4'b1011);
    pulse2();
    check(torFlag == 2'b10 && queueStatus == 4'b1011, "R7 tor2 on second trigger",
          {torFlag, queueStatus}, 6'b101011);
    waitStatus(4'b0001);
    clr(6'b111111);
    // R6: paused queue 2 made pending resumes after its pause point
    push(0, 0, 0); push(0, 0, 1); push(0, 0, 2);
    push(0, 1, 18); push(0, 1, 19);
    pulse1();
    pulse2();
    check(queueStatus == 4'b1011, "R6 paused q2 pending", queueStatus, 4'b1011);
    waitStatus(4'b0000);
    check(compFlag == 2'b11 && expQ.size() == 0, "R6 resume order", {compFlag, 4'(expQ.size())}, 6'b110000);
    clr(6'b111111);

    // R8/R9: queue 1 retrigger with simultaneous clear
    push(0, 0, 0); push(0, 0, 1); push(0, 0, 2);
    pulse1();
    @(negedge clk);
    trig1 = 1'b1; flagClr = 6'b010000;
    @(negedge clk);
    trig1 = 1'b0; flagClr = '0;
    check(torFlag == 2'b01, "R8 R9 tor1 set wins over clear", torFlag, 2'b01);
    waitStatus(4'b0000);
    check(expQ.size() == 0, "R8 no extra start", expQ.size(), 0);
    clr(6'b010000);
    check(torFlag == 2'b00, "R9 tor1 cleared", torFlag, 0);

    // R7: queue 2 retrigger while active
    push(0, 1, 16); push(0, 1, 17);
    pulse2();
    pulse2();
    check(torFlag == 2'b10 && queueStatus == 4'b0010, "R7 tor2 while active",
          {torFlag, queueStatus}, 6'b100010);
    waitStatus(4'b0001);
    push(0, 1, 18); push(0, 1, 19);
    pulse2();
    waitStatus(4'b0000);
    clr(6'b111111);

    // R3: queue ends at its last slot without an end marker
    for (int i = 0; i < 64; i++) tab[i] = 2'b00;
    for (int i = 0; i < 16; i++) push(0, 0, i);
    pulse1();
    waitStatus(4'b0000);
    check(compFlag == 2'b01 && expQ.size() == 0, "R3 implicit end", {compFlag, 5'(expQ.size())}, 7'b0100000);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule